// File: doc/BRIEF.md
# Reuse-Factor Dense Layer Engine

This block evaluates one fully connected neural-network layer, y = W·x + b, on signed two's-complement fixed-point data. It takes an input vector of N_IN values through a valid/ready handshake and returns M_OUT results together with a one-cycle valid pulse. The weight matrix and the bias vector are constants fixed at elaboration. They are computed by package functions and held in small per-lane read-only tables.

The parameter RF sets the trade between multiplier count and throughput. The engine contains exactly P = M_OUT·N_IN/RF multipliers, and it spreads the M_OUT·N_IN weight products over RF compute cycles. The products are flattened in the order k = cycle·P + lane. Product k multiplies input k mod N_IN by the weight of output k / N_IN, and it is added to accumulator k / N_IN. When P exceeds N_IN the input selection wraps around, so one input can feed several lanes in the same cycle. Each accumulator starts from its bias value. When the vector is complete, the results are clamped to OUT_W bits.

Top module: `dense_rf_layer`

## Requirements
- R1: While reset is asserted and right after it, in_ready is 1 and out_valid is 0.
- R2: A vector is accepted on a rising edge where in_valid and in_ready are both 1. From the next cycle, in_ready stays 0 until the cycle after out_valid.
- R3: out_valid is high for exactly one cycle. It first appears RF clock edges after the accepting edge, and in_ready is 1 in the following cycle.
- R4: Input value i occupies in_data[i*DATA_W +: DATA_W] and result o occupies out_data[o*OUT_W +: OUT_W], all signed two's-complement. With the default constants, the weight of output o and input i is ((5o+3i+2) mod 11) − 5, and the bias of output o is 37o − 50. Each result equals the bias plus the sum of weight × input over all inputs.
- R5: A result above 2^(OUT_W−1)−1 is output as 2^(OUT_W−1)−1, and a result below −2^(OUT_W−1) is output as −2^(OUT_W−1).
- R6: in_valid and in_data are ignored while a vector is being processed. The result reflects only the accepted vector.
- R7: The result is correct for RF values where P < N_IN, P = 1, and P > N_IN (input selection wraps within one cycle).
- R8: The accumulator never overflows. Its width covers N_IN full-precision products plus the bias.
- R9: Every vector starts from the bias values. A vector accepted in the cycle right after out_valid is unaffected by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input vector is offered |
| in_ready | output | 1 | Engine is idle and can accept a vector |
| in_data | input | N_IN*DATA_W | Packed signed input vector |
| out_valid | output | 1 | One-cycle pulse: results are valid |
| out_data | output | M_OUT*OUT_W | Packed signed saturated results |

## Verification
The assertions assume that RF divides M_OUT·N_IN, so every compute cycle maps each lane to a real output index. They also assume that OUT_W is narrower than the accumulator. The bench builds three instances of the engine, with RF = 4, 2 and 12. All of them keep the default constant weights and biases, so no value can exceed the accumulator bound.

The stimulus covers extreme inputs, −128 and 127. Some of these vectors drive results past the OUT_W range, which exercises saturation. In one sequence in_valid is held high with different data throughout the busy window, which checks that input is ignored while a vector is in flight.

// File: rtl/dense_pkg.sv
package dense_pkg;
  // Constant weight for output o, input i (small signed values).
  function automatic int wgt_val(input int o, input int i);
    return ((o * 5 + i * 3 + 2) % 11) - 5;
  endfunction

  // Constant bias for output o.
  function automatic int bias_val(input int o);
    return o * 37 - 50;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } eng_state_t;
endpackage

// File: rtl/dense_ctrl.sv
module dense_ctrl #(
  parameter int RF    = 4,
  parameter int CYC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             load,
  output logic             run,
  output logic             out_valid,
  output logic [CYC_W-1:0] cyc
);
  import dense_pkg::*;

  localparam int LAT_W = $clog2(RF + 1) + 1;

  eng_state_t       st_q, st_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [LAT_W-1:0] lat_q, lat_d;

  // next-state logic
  always_comb begin
    st_d      = st_q;
    cyc_d     = cyc_q;
    in_ready  = 1'b0;
    load      = 1'b0;
    run       = 1'b0;
    out_valid = 1'b0;
    case (st_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          load  = 1'b1;
          cyc_d = '0;
          st_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        run = 1'b1;
        if (cyc_q == CYC_W'(RF - 1)) st_d = ST_DONE;
        else                         cyc_d = cyc_q + 1'b1;
      end
      ST_DONE: begin
        out_valid = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // independent latency counter used by the checker
  always_comb begin
    lat_d = lat_q;
    if (load)     lat_d = '0;
    else if (run) lat_d = lat_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
      lat_q <= '0;
    end else begin
      st_q  <= st_d;
      cyc_q <= cyc_d;
      lat_q <= lat_d;
    end
  end

  assign cyc = cyc_q;

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (!out_valid && in_ready)); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_q == LAT_W'(RF))); // R3
endmodule

// File: rtl/dense_lane.sv
module dense_lane #(
  parameter int LANE   = 0,
  parameter int N_IN   = 4,
  parameter int M_OUT  = 3,
  parameter int RF     = 4,
  parameter int P      = 3,
  parameter int DATA_W = 8,
  parameter int W_W    = 8,
  parameter int CYC_W  = 2,
  parameter int OIX_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run,
  input  logic [CYC_W-1:0]               cyc,
  input  logic [N_IN*DATA_W-1:0]         x_flat,
  output logic signed [DATA_W+W_W-1:0]   prod,
  output logic [OIX_W-1:0]               oix
);
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic signed [W_W-1:0]    rom [RF];
  logic [IDX_W-1:0]         idx;
  logic signed [DATA_W-1:0] xsel;
  logic signed [W_W-1:0]    wsel;

  // per-lane weight table: entry c holds the weight of product c*P+LANE
  always_comb begin
    for (int c = 0; c < RF; c++) begin
      rom[c] = W_W'(dense_pkg::wgt_val((c * P + LANE) / N_IN, (c * P + LANE) % N_IN));
    end
  end

  // rotating input selection with wrap-around
  always_comb begin
    int k;
    k    = int'(cyc) * P + LANE;
    idx  = IDX_W'(k % N_IN);
    oix  = OIX_W'(k / N_IN);
    xsel = $signed(x_flat[int'(idx)*DATA_W +: DATA_W]);
    wsel = rom[cyc];
    prod = xsel * wsel;
  end

  AST_LANE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((int'(oix) < M_OUT) && (int'(idx) < N_IN))); // R7
endmodule

// File: rtl/dense_accum.sv
module dense_accum #(
  parameter int M_OUT = 3,
  parameter int P     = 3,
  parameter int PW    = 16,
  parameter int ACC_W = 20,
  parameter int OIX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    run,
  input  logic signed [PW-1:0]    prod [P],
  input  logic [OIX_W-1:0]        oix  [P],
  output logic signed [ACC_W-1:0] acc  [M_OUT]
);
  logic signed [ACC_W-1:0] acc_q [M_OUT];
  logic signed [ACC_W-1:0] acc_d [M_OUT];
  logic signed [ACC_W:0]   sum_w [M_OUT];

  // next-state: bias load, or add every lane routed to this output
  always_comb begin
    for (int o = 0; o < M_OUT; o++) begin
      sum_w[o] = (ACC_W+1)'(acc_q[o]);
      for (int l = 0; l < P; l++) begin
        if (int'(oix[l]) == o) sum_w[o] = sum_w[o] + (ACC_W+1)'(prod[l]);
      end
      if (load)     acc_d[o] = ACC_W'(dense_pkg::bias_val(o));
      else if (run) acc_d[o] = sum_w[o][ACC_W-1:0];
      else          acc_d[o] = acc_q[o];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < M_OUT; o++) acc_q[o] <= '0;
    end else if (load || run) begin
      for (int o = 0; o < M_OUT; o++) acc_q[o] <= acc_d[o];
    end
  end

  assign acc = acc_q;

  for (genvar g = 0; g < M_OUT; g++) begin : g_ovf
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (sum_w[g][ACC_W] == sum_w[g][ACC_W-1])); // R8
  end
endmodule

// File: rtl/dense_rf_layer.sv
module dense_rf_layer #(
  parameter int N_IN   = 4,
  parameter int M_OUT  = 3,
  parameter int RF     = 4,
  parameter int DATA_W = 8,
  parameter int W_W    = 8,
  parameter int OUT_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic                     out_valid,
  output logic [M_OUT*OUT_W-1:0]   out_data
);
  localparam int P     = (M_OUT * N_IN) / RF;
  localparam int PW    = DATA_W + W_W;
  localparam int ACC_W = PW + $clog2(N_IN) + 2;
  localparam int CYC_W = (RF > 1) ? $clog2(RF) : 1;
  localparam int OIX_W = (M_OUT > 1) ? $clog2(M_OUT) : 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  if (((M_OUT * N_IN) % RF) != 0 || RF < 1) begin : g_bad_rf
    $error("RF must divide M_OUT*N_IN");
  end

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_i_n;
  assign rst_i_n = rst_s2_q & rst_n;

  logic             load, run;
  logic [CYC_W-1:0] cyc;

  dense_ctrl #(.RF(RF), .CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .run(run), .out_valid(out_valid), .cyc(cyc)
  );

  // input vector register with explicit enable
  logic [N_IN*DATA_W-1:0] x_q, x_d;
  always_comb x_d = load ? in_data : x_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) x_q <= '0;
    else          x_q <= x_d;
  end

  logic signed [PW-1:0]  prod [P];
  logic [OIX_W-1:0]      oix  [P];

  for (genvar l = 0; l < P; l++) begin : g_lane
    dense_lane #(
      .LANE(l), .N_IN(N_IN), .M_OUT(M_OUT), .RF(RF), .P(P),
      .DATA_W(DATA_W), .W_W(W_W), .CYC_W(CYC_W), .OIX_W(OIX_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_i_n), .run(run), .cyc(cyc),
      .x_flat(x_q), .prod(prod[l]), .oix(oix[l])
    );
  end

  logic signed [ACC_W-1:0] acc [M_OUT];

  dense_accum #(
    .M_OUT(M_OUT), .P(P), .PW(PW), .ACC_W(ACC_W), .OIX_W(OIX_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_i_n), .load(load), .run(run),
    .prod(prod), .oix(oix), .acc(acc)
  );

  // saturating narrowing to OUT_W
  for (genvar o = 0; o < M_OUT; o++) begin : g_sat
    always_comb begin
      if (acc[o] > SAT_HI)      out_data[o*OUT_W +: OUT_W] = SAT_HI[OUT_W-1:0];
      else if (acc[o] < SAT_LO) out_data[o*OUT_W +: OUT_W] = SAT_LO[OUT_W-1:0];
      else                      out_data[o*OUT_W +: OUT_W] = acc[o][OUT_W-1:0];
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid)); // R1
endmodule

// File: tb/sim_dense_rf_layer.sv
module sim_dense_rf_layer;
  localparam int N  = 4;
  localparam int M  = 3;
  localparam int DW = 8;
  localparam int OW = 10;
  localparam int NV = 7;
  // stimulus vectors, input 0 in the low byte
  localparam logic [31:0] STIM [NV] = '{
    32'h00000000, 32'h01020304, 32'hFF7F8001, 32'h007F7F7F,
    32'h00807F7F, 32'h007F8080, 32'h80808080
  };
  localparam int RFS [3] = '{4, 2, 12};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [N*DW-1:0]    x;
  logic               iv  [3];
  logic               rdy [3];
  logic               ov  [3];
  logic [M*OW-1:0]    od  [3];
  int                 n_chk = 0;
  int                 n_bad = 0;
  bit                 done  = 1'b0;

  dense_rf_layer #(.N_IN(N), .M_OUT(M), .RF(4),  .DATA_W(DW), .W_W(8), .OUT_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(rdy[0]),
    .in_data(x), .out_valid(ov[0]), .out_data(od[0]));
  dense_rf_layer #(.N_IN(N), .M_OUT(M), .RF(2),  .DATA_W(DW), .W_W(8), .OUT_W(OW)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(rdy[1]),
    .in_data(x), .out_valid(ov[1]), .out_data(od[1]));
  dense_rf_layer #(.N_IN(N), .M_OUT(M), .RF(12), .DATA_W(DW), .W_W(8), .OUT_W(OW)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[2]), .in_ready(rdy[2]),
    .in_data(x), .out_valid(ov[2]), .out_data(od[2]));

  function automatic int model(input logic [31:0] v, input int o);
    int s;
    s = o * 37 - 50;
    for (int i = 0; i < N; i++)
      s += (((o * 5 + i * 3 + 2) % 11) - 5) * int'($signed(v[i*8 +: 8]));
    if (s > 511)  s = 511;
    if (s < -512) s = -512;
    return s;
  endfunction

  function automatic int field(input logic [M*OW-1:0] d, input int o);
    return int'($signed(d[o*OW +: OW]));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_res(input int s, input logic [31:0] v, input string req);
    for (int o = 0; o < M; o++)
      check(field(od[s], o) == model(v, o), req, field(od[s], o), model(v, o));
  endtask

  // wait from the negedge after acceptance until out_valid; returns latency
  task automatic wait_out(input int s, output int lat);
    lat = 0;
    while (!ov[s] && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(input int s, input logic [31:0] v, input string req);
    int lat;
    @(negedge clk);
    x = v;
    iv[s] = 1'b1;
    @(negedge clk);
    iv[s] = 1'b0;
    x = ~v;
    check(rdy[s] == 1'b0, "R2", int'(rdy[s]), 0);
    wait_out(s, lat);
    check(lat == RFS[s], "R3", lat, RFS[s]);
    check_res(s, v, req);
    @(negedge clk);
    check(ov[s] == 1'b0 && rdy[s] == 1'b1, "R3", int'({ov[s], rdy[s]}), 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int lat;
    rst_n = 1'b0;
    x = '0;
    for (int s = 0; s < 3; s++) iv[s] = 1'b0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 3; s++)
      check(rdy[s] == 1'b1 && ov[s] == 1'b0, "R1", int'({rdy[s], ov[s]}), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rdy[0] == 1'b1 && ov[0] == 1'b0, "R1", int'({rdy[0], ov[0]}), 2);

    // table walk on every instance: R4, R7 (P=3, P=6 wrap, P=1)
    for (int s = 0; s < 3; s++)
      for (int v = 0; v < NV; v++)
        run_one(s, STIM[v], (s == 0) ? "R4" : "R7");

    // R5: saturation on both ends
    @(negedge clk);
    x = 32'h00807F7F; iv[0] = 1'b1;
    @(negedge clk); iv[0] = 1'b0;
    wait_out(0, lat);
    check(field(od[0], 1) == 511, "R5", field(od[0], 1), 511);
    @(negedge clk);
    x = 32'h007F8080; iv[0] = 1'b1;
    @(negedge clk); iv[0] = 1'b0;
    wait_out(0, lat);
    check(field(od[0], 1) == -512, "R5", field(od[0], 1), -512);

    // R6 / R9: hold in_valid with other data while busy, then back-to-back
    @(negedge clk);
    x = 32'h01020304; iv[0] = 1'b1;
    @(negedge clk);
    x = 32'h00000000;
    wait_out(0, lat);
    check_res(0, 32'h01020304, "R6");
    @(negedge clk);
    check(rdy[0] == 1'b1, "R9", int'(rdy[0]), 1);
    @(negedge clk);
    iv[0] = 1'b0;
    wait_out(0, lat);
    check(lat == 4, "R9", lat, 4);
    check_res(0, 32'h00000000, "R9");

    // R1: reset in the middle of a vector
    @(negedge clk);
    x = 32'h7F7F7F7F; iv[1] = 1'b1;
    @(negedge clk); iv[1] = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(rdy[1] == 1'b1 && ov[1] == 1'b0, "R1", int'({rdy[1], ov[1]}), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_one(1, 32'hFF7F8001, "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule